// File: doc/BRIEF.md
# I2C Control-Register Slave

This block is a two-wire serial slave that exposes a small bank of control registers through a device address of its own. It watches SCL and SDA through synchronizers on a fast system clock and finds START, repeated START and STOP conditions. It shifts bytes in and out and drives the acknowledge bit through an open-drain output enable. Register contents stay outside the block. They are reached through a parallel port: a combinational read path and a one-cycle write strobe.

A master sets the register pointer with a write transaction. After the pointer byte, the master either sends data bytes, which are written in turn, or issues a repeated START and reads. Reads auto-increment through the readable window and wrap back to the bottom of it. The pointer keeps its value between transactions, so a read that supplies no address continues where the last access stopped. A write-only command location sits outside the readable window. It is never returned by a read: a read whose pointer rests on it starts at the bottom of the map. A pointer byte that is neither readable nor the command location is refused.

Top module: `i2c_creg_slave`

## Requirements
- R1: The first byte after a START is a device byte, taken MSB first: bits 7..4 must be 0011, bit 3 must equal `strap_a2`, bit 2 must equal `strap_a1`, bit 1 is ignored and bit 0 selects read (1) or write (0). On a match the slave pulls SDA low in the acknowledge slot that follows.
- R2: A device byte that does not match is not acknowledged. Until the next START, the slave drives nothing, writes nothing and leaves the pointer unchanged.
- R3: In a write transaction, the byte after the device byte is a pointer byte. A pointer in 0x00..LAST_RD, or equal to the command location (0xAA), is acknowledged and becomes the pointer. A read after a repeated START starts from that pointer.
- R4: A pointer byte outside 0x00..LAST_RD that is not 0xAA is refused with SDA left high in its acknowledge slot. The pointer is kept and no write happens.
- R5: Each data byte after an accepted pointer is acknowledged and written through a one-cycle `reg_we` pulse at the current pointer. The pointer then advances by one. It returns to 0x00 after LAST_RD and after 0xAA.
- R6: A read transaction with no pointer byte starts at the pointer left by the previous access, which after reset is 0x00.
- R7: Each byte the master acknowledges during a read is followed by the next readable register. After LAST_RD the next byte comes from 0x00.
- R8: A read whose pointer is 0xAA returns the register at 0x00 first and goes on from there. The address 0xAA never appears on `reg_addr` for a read.
- R9: When the master does not acknowledge a read byte, the slave releases SDA. The pointer stays one past the last byte returned, with the same wrap rule.
- R10: During and after reset SDA is released and no write is strobed. A START or repeated START at any point restarts the device-byte phase, and a STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_a2 | input | 1 | Expected value of device byte bit 3 |
| strap_a1 | input | 1 | Expected value of device byte bit 2 |
| reg_addr | output | AW | Register address for the write strobe or the read path |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, a combinational function of `reg_addr` |

## Verification
The collision that matters is in the cycle that loads a read byte. In that one system cycle the pointer is redirected away from 0xAA or wrapped at LAST_RD, and it is also advanced for the next byte. Directed reads start at 0xAA and at LAST_RD, and random transactions pick those two pointers often, mixed with writes that leave the pointer on them. Every returned byte, and the byte returned by the next current-address read, is compared with a pointer model kept in the bench.

// File: rtl/creg_pkg.sv
package creg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/creg_busmon.sv
module creg_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic                   scl_d;
  logic                   sda_d;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
          end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[g] <= 1'b1;
            sda_ff[g] <= 1'b1;
          end else begin
            scl_ff[g] <= scl_ff[g-1];
            sda_ff[g] <= sda_ff[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/creg_shreg.sv
module creg_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (load_en) begin
      q_n = load_val;
    end else if (shift_en) begin
      q_n = {q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en || shift_en) begin
      q <= q_n;
    end
  end

endmodule

// File: rtl/creg_ptr.sv
module creg_ptr #(
  parameter int AW       = 8,
  parameter int LAST_RD  = 15,
  parameter int CMD_ADDR = 170
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cand,
  input  logic          load_en,
  input  logic          adv_wr,
  input  logic          adv_rd,
  output logic          cand_ok,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] rd_addr
);

  localparam logic [AW-1:0] LAST_A = AW'(LAST_RD);
  localparam logic [AW-1:0] CMD_A  = AW'(CMD_ADDR);
  localparam logic [AW-1:0] ONE_A  = AW'(1);

  logic [AW-1:0] ptr_n;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    if (a >= LAST_A || a == CMD_A) begin
      return '0;
    end
    return a + ONE_A;
  endfunction

  assign cand_ok = (cand <= LAST_A) || (cand == CMD_A);
  assign rd_addr = (ptr == CMD_A) ? '0 : ptr;

  always_comb begin
    ptr_n = ptr;
    if (load_en) begin
      ptr_n = cand;
    end else if (adv_wr) begin
      ptr_n = step(ptr);
    end else if (adv_rd) begin
      ptr_n = step(rd_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_en || adv_wr || adv_rd) begin
      ptr <= ptr_n;
    end
  end

endmodule

// File: rtl/i2c_creg_slave.sv
module i2c_creg_slave #(
  parameter int AW          = 8,
  parameter int LAST_RD     = 15,
  parameter int CMD_ADDR    = 170,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          strap_a2,
  input  logic          strap_a1,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);

  import creg_pkg::*;

  localparam int            CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  // bus edge and condition detection
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  creg_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // byte shifter shared by receive and transmit
  logic              sh_load, sh_shift, sh_bit;
  logic [BYTE_W-1:0] sh_q;

  creg_shreg #(.W(BYTE_W)) u_sh (
    .clk      (clk),
    .rst_n    (rst_s),
    .load_en  (sh_load),
    .load_val (reg_rdata),
    .shift_en (sh_shift),
    .bit_in   (sh_bit),
    .q        (sh_q)
  );

  // register pointer
  logic          ptr_load, ptr_adv_wr, ptr_adv_rd, ptr_ok;
  logic [AW-1:0] ptr_q, rd_addr;

  creg_ptr #(.AW(AW), .LAST_RD(LAST_RD), .CMD_ADDR(CMD_ADDR)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_s),
    .cand    (AW'(sh_q)),
    .load_en (ptr_load),
    .adv_wr  (ptr_adv_wr),
    .adv_rd  (ptr_adv_rd),
    .cand_ok (ptr_ok),
    .ptr     (ptr_q),
    .rd_addr (rd_addr)
  );

  // control state
  slv_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              oe_q, oe_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              we_q, we_n;
  logic [AW-1:0]     waddr_q, waddr_n;
  logic [7:0]        wdata_q, wdata_n;

  logic byte_done, dev_match, receiving;

  assign byte_done = (cnt_q == CNT_FULL);
  assign dev_match = (sh_q[7:4] == 4'b0011) && (sh_q[3] == strap_a2) &&
                     (sh_q[2] == strap_a1);
  assign receiving = (st_q == ST_DEV) || (st_q == ST_PTR) || (st_q == ST_WR);

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    oe_n       = oe_q;
    rw_n       = rw_q;
    mack_n     = mack_q;
    we_n       = 1'b0;
    waddr_n    = waddr_q;
    wdata_n    = wdata_q;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    sh_bit     = 1'b0;
    ptr_load   = 1'b0;
    ptr_adv_wr = 1'b0;
    ptr_adv_rd = 1'b0;

    if (start_det) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (receiving) begin
      if (scl_rise && !byte_done) begin
        sh_shift = 1'b1;
        sh_bit   = sda_s;
        cnt_n    = cnt_q + CNT_ONE;
      end else if (scl_fall && byte_done) begin
        cnt_n = '0;
        unique case (st_q)
          ST_DEV: begin
            if (dev_match) begin
              oe_n = 1'b1;
              rw_n = sh_q[0];
              st_n = ST_DEV_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
          ST_PTR: begin
            if (ptr_ok) begin
              oe_n     = 1'b1;
              ptr_load = 1'b1;
              st_n     = ST_PTR_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
          default: begin
            oe_n       = 1'b1;
            we_n       = 1'b1;
            waddr_n    = ptr_q;
            wdata_n    = sh_q;
            ptr_adv_wr = 1'b1;
            st_n       = ST_WR_ACK;
          end
        endcase
      end
    end else begin
      unique case (st_q)
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_load    = 1'b1;
              ptr_adv_rd = 1'b1;
              oe_n       = ~reg_rdata[7];
              cnt_n      = '0;
              st_n       = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            st_n = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_n = 1'b0;
              st_n = ST_RD_ACK;
            end else begin
              cnt_n    = cnt_q + CNT_ONE;
              sh_shift = 1'b1;
              oe_n     = ~sh_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_load    = 1'b1;
              ptr_adv_rd = 1'b1;
              oe_n       = ~reg_rdata[7];
              cnt_n      = '0;
              st_n       = ST_RD;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: begin
          st_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      oe_q   <= oe_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
      we_q   <= we_n;
      if (we_n) begin
        waddr_q <= waddr_n;
        wdata_q <= wdata_n;
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = we_q ? waddr_q : rd_addr;

endmodule

// File: rtl/creg_checker.sv
module creg_checker #(
  parameter int AW       = 8,
  parameter int LAST_RD  = 15,
  parameter int CMD_ADDR = 170
) (
  input logic                 clk,
  input logic                 rst_n,
  input creg_pkg::slv_state_t st,
  input logic                 sda_oe,
  input logic                 scl_s,
  input logic                 start_det,
  input logic                 stop_det,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [AW-1:0]        ptr,
  input logic                 rd_load
);

  import creg_pkg::*;

  localparam logic [AW-1:0] LAST_A = AW'(LAST_RD);
  localparam logic [AW-1:0] CMD_A  = AW'(CMD_ADDR);

  assert_ptr_in_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr <= LAST_A) || (ptr == CMD_A));

  assert_write_addr_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ((reg_addr <= LAST_A) || (reg_addr == CMD_A)));

  assert_write_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_no_cmd_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> (reg_addr != CMD_A));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  assert_ptr_ack_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PTR_ACK) |-> sda_oe);

  assert_release_on_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  assert_oe_moves_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

bind i2c_creg_slave creg_checker #(
  .AW       (AW),
  .LAST_RD  (LAST_RD),
  .CMD_ADDR (CMD_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .st        (st_q),
  .sda_oe    (sda_oe),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ptr       (ptr_q),
  .rd_load   (ptr_adv_rd)
);

// File: tb/i2c_creg_slave_test.sv
`timescale 1ns/1ps
module i2c_creg_slave_test;

  localparam int LAST = 15;
  localparam int CMD  = 170;
  localparam int H    = 8;
  localparam int Q    = 2;
  localparam bit A2   = 1'b1;
  localparam bit A1   = 1'b0;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       m_low;
  wire        sda_line;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  logic [7:0] mem  [256];
  logic [7:0] emem [256];
  int         wr_seen;
  int         mptr;
  int         n_chk;
  int         n_fail;
  bit         done;

  assign sda_line  = ~(m_low | sda_oe);
  assign reg_rdata = mem[reg_addr];

  i2c_creg_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .strap_a2  (A2),
    .strap_a1  (A1),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic int nxt(input int p);
    return (p >= LAST || p == CMD) ? 0 : p + 1;
  endfunction

  function automatic int effa(input int p);
    return (p == CMD) ? 0 : p;
  endfunction

  function automatic bit okp(input int p);
    return (p <= LAST) || (p == CMD);
  endfunction

  function automatic logic [7:0] devb(input bit rw, input bit x, input bit good);
    return {4'b0011, good ? A2 : ~A2, A1, x, rw};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      wr_seen <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wr_seen <= wr_seen + 1;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_low = 1'b0; wt(H); scl_m = 1'b1; wt(H);
    m_low = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    m_low = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    end
    m_low = 1'b0; wt(H); scl_m = 1'b1; wt(H / 2);
    acked = ~sda_line;
    wt(H / 2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_m = 1'b1; wt(H / 2);
      b[i] = sda_line;
      wt(H / 2); scl_m = 1'b0; wt(Q);
    end
    m_low = ack_it; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    m_low = 1'b0;
  endtask

  task automatic check_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic do_reads(input int n, input string req);
    logic [7:0] got;
    int a;
    for (int k = 0; k < n; k++) begin
      a = effa(mptr);
      mptr = nxt(a);
      recv_byte(k < n - 1, got);
      chk(got == emem[a], req, got, emem[a]);
    end
    m_stop();
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);
  endtask

  task automatic tr_write(input int p, input int n, input bit xbit);
    bit ack;
    int w0;
    logic [7:0] d;
    w0 = wr_seen;
    m_start();
    send_byte(devb(1'b0, xbit, 1'b1), ack);
    chk(ack, "R1", ack, 1);
    send_byte(8'(p), ack);
    if (!okp(p)) begin
      chk(!ack, "R4", ack, 0);
      m_stop();
      chk(wr_seen == w0, "R4", wr_seen - w0, 0);
      return;
    end
    chk(ack, "R3", ack, 1);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(ack, "R5", ack, 1);
      emem[mptr] = d;
      mptr = nxt(mptr);
    end
    m_stop();
    chk(wr_seen - w0 == n, "R5", wr_seen - w0, n);
    check_mem("R5");
  endtask

  task automatic tr_rand_read(input int p, input int n, input string req);
    bit ack;
    m_start();
    send_byte(devb(1'b0, 1'b0, 1'b1), ack);
    chk(ack, "R1", ack, 1);
    send_byte(8'(p), ack);
    if (!okp(p)) begin
      chk(!ack, "R4", ack, 0);
      m_stop();
      return;
    end
    chk(ack, "R3", ack, 1);
    mptr = p;
    m_start();
    send_byte(devb(1'b1, 1'b0, 1'b1), ack);
    chk(ack, "R10", ack, 1);
    do_reads(n, req);
  endtask

  task automatic tr_cur_read(input int n, input bit xbit);
    bit ack;
    m_start();
    send_byte(devb(1'b1, xbit, 1'b1), ack);
    chk(ack, "R1", ack, 1);
    do_reads(n, "R6");
  endtask

  task automatic tr_bad_dev();
    bit ack;
    int w0;
    w0 = wr_seen;
    m_start();
    send_byte(devb(1'b0, 1'b0, 1'b0), ack);
    chk(!ack, "R2", ack, 0);
    send_byte(8'h03, ack);
    chk(!ack, "R2", ack, 0);
    send_byte(8'h5A, ack);
    chk(!ack, "R2", ack, 0);
    m_stop();
    chk(wr_seen == w0, "R2", wr_seen - w0, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    wt(180000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p, r;
    void'($urandom(32'd20240611));
    m_low = 1'b0; scl_m = 1'b1; rst_n = 1'b0; mptr = 0;
    for (int i = 0; i < 256; i++) emem[i] = pat(i);
    wt(10);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    chk(reg_we == 1'b0, "R10", reg_we, 0);
    rst_n = 1'b1;
    wt(8);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);

    tr_cur_read(2, 1'b0);          // R6: from 0x00 after reset
    tr_write(LAST, 2, 1'b0);       // R5: wrap after LAST_RD
    tr_rand_read(LAST, 3, "R7");   // R7: LAST, 0, 1
    tr_rand_read(CMD, 2, "R8");    // R8: 0xAA redirected to 0x00
    tr_write(CMD, 1, 1'b1);        // R5: command write, pointer to 0x00
    tr_cur_read(1, 1'b1);          // R6, R1 with X bit set
    tr_rand_read(LAST + 1, 1, "R4");
    tr_cur_read(2, 1'b0);          // R4: pointer kept
    tr_bad_dev();
    tr_cur_read(1, 1'b0);          // R2: pointer untouched
    tr_write(3, 0, 1'b0);          // R3: pointer only
    tr_cur_read(2, 1'b0);

    for (int t = 0; t < 40; t++) begin
      r = int'($urandom % 4);
      case (r)
        0: p = int'($urandom % (LAST + 1));
        1: p = LAST;
        2: p = CMD;
        default: p = int'($urandom % 256);
      endcase
      r = int'($urandom % 8);
      if (r < 2) tr_write(p, int'($urandom % 4), 1'b0);
      else if (r < 4) tr_rand_read(p, 1 + int'($urandom % 5), "R7");
      else if (r < 7) tr_cur_read(1 + int'($urandom % 4), r[0]);
      else tr_bad_dev();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule